// File: doc/BRIEF.md
# Tightly Coupled Data Memory Requester

This block sits between a load/store unit and a data tightly coupled memory that takes one access per request cycle. The internal side presents a byte address, an access size, a read/write flag and write data, and holds them steady. If the access fits inside the attached memory, the block raises chip select. In the next cycle it presents the word address, the byte-lane strobes and the lane-aligned write data. That cycle is the request cycle.

The memory can refuse a request cycle by raising its wait input. The block then repeats the identical request in every following cycle until wait is low. At that point it pulses done to the internal side, with the read data attached for loads.

A static 4-bit configuration input gives the size of the attached memory. If the code is absent or reserved, or the address lies past the decoded capacity, the block issues nothing to the memory. It answers the internal side with a one-cycle error pulse instead.

Top module: `tcm_req`

## Requirements
- R1: Size codes 3 to 11 give a capacity of 2^(code+9) bytes (3 = 4 KB, 4 = 8 KB, 11 = 1 MB). Codes 0, 1, 2 and 12 to 15 mean no usable memory: every request is rejected and chip select never rises.
- R2: A held request with a byte address at or above the capacity gives `rsp_err` high in the same cycle, with `tcm_cs` low. The block stays idle.
- R3: An idle, valid, in-range request raises `tcm_cs` in that cycle. The next cycle is the request cycle, with `tcm_addr` equal to byte address bits [19:2].
- R4: If `tcm_wait` is high in a request cycle, the next cycle is again a request cycle with the same `tcm_addr`, `tcm_strb` and `tcm_wdata`. `tcm_cs` stays low during such repeated cycles.
- R5: `rsp_done` is high exactly in a request cycle with `tcm_wait` low. For reads, `rsp_rdata` then equals `tcm_rdata`. `rsp_rdata` is zero in every other cycle.
- R6: `tcm_wait` has no effect outside request cycles. It neither blocks chip select nor produces done or error.
- R7: For reads, `tcm_strb` is 0000. Outside request cycles, `tcm_strb` is 0000 for every access.
- R8: `req_size` encodes 00 = byte, 01 = halfword, 10 or 11 = word. A word write strobes 1111. A halfword write strobes 1100 when address bit 1 is set and 0011 when it is clear. A byte write strobes only lane addr[1:0].
- R9: `tcm_wdata` carries a byte write's low byte copied into all four lanes and a halfword write's low half copied into both halves. A word is passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 4 | Static memory size code |
| req_valid | input | 1 | Internal request present, held until done or error |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_done | output | 1 | Access completed this cycle |
| rsp_err | output | 1 | Access rejected this cycle |
| rsp_rdata | output | 32 | Load data, valid with done |
| tcm_cs | output | 1 | Access follows in the next cycle |
| tcm_addr | output | WAW | Word address |
| tcm_strb | output | 4 | Byte-lane write strobes |
| tcm_wdata | output | 32 | Lane-aligned write data |
| tcm_wait | input | 1 | Memory cannot accept this request cycle |
| tcm_rdata | input | 32 | Read data from memory |

## Verification
The state register and the captured request are the only memory in the block. A stuck or wrong state shows up one cycle after chip select as missing strobes, as a done that comes early or never, or as chip select that does not rise for the next request. A captured field that changes during waits shows up at once on `tcm_addr`, `tcm_strb` or `tcm_wdata` in the repeated cycle. The bench therefore compares every output in every cycle of each transaction, including each waited cycle. Decoder faults appear in the same cycle as a wrong error or chip-select level, so the bench sweeps all sixteen size codes at their capacity edges.

// File: rtl/tcm_req_pkg.sv
package tcm_req_pkg;
  localparam int DW = 32;
  localparam int NLANE = DW / 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } req_state_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  localparam logic [3:0] CODE_MIN = 4'd3;
  localparam logic [3:0] CODE_MAX = 4'd11;
  localparam int CAP_BIAS = 9;
endpackage

// File: rtl/tcm_size_decode.sv
module tcm_size_decode
  import tcm_req_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [3:0]    size_code,
  input  logic [AW-1:0] byte_addr,
  output logic          present,
  output logic          in_range
);
  logic [4:0] cap_shift;

  always_comb begin
    present   = (size_code >= CODE_MIN) && (size_code <= CODE_MAX);
    cap_shift = 5'(size_code) + 5'(CAP_BIAS);
    in_range  = present && ((byte_addr >> cap_shift) == '0);
  end
endmodule

// File: rtl/tcm_lane_gen.sv
module tcm_lane_gen
  import tcm_req_pkg::*;
(
  input  logic             is_write,
  input  logic [1:0]       acc_size,
  input  logic [1:0]       lsb,
  input  logic [DW-1:0]    wdata,
  output logic [NLANE-1:0] strb,
  output logic [DW-1:0]    lane_data
);
  logic [NLANE-1:0] byte_strb;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      assign byte_strb[g] = (lsb == 2'(g));
    end
  endgenerate

  always_comb begin
    strb      = '0;
    lane_data = wdata;
    if (acc_size == SZ_BYTE) begin
      lane_data = {NLANE{wdata[7:0]}};
      if (is_write) strb = byte_strb;
    end else if (acc_size == SZ_HALF) begin
      lane_data = {2{wdata[15:0]}};
      if (is_write) strb = lsb[1] ? 4'b1100 : 4'b0011;
    end else begin
      if (is_write) strb = '1;
    end
  end
endmodule

// File: rtl/tcm_req.sv
module tcm_req
  import tcm_req_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WAW = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cfg_size,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             tcm_cs,
  output logic [WAW-1:0]   tcm_addr,
  output logic [NLANE-1:0] tcm_strb,
  output logic [DW-1:0]    tcm_wdata,
  input  logic             tcm_wait,
  input  logic [DW-1:0]    tcm_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic             present, in_range;
  logic [NLANE-1:0] strb_d;
  logic [DW-1:0]    lane_d;

  tcm_size_decode #(.AW(AW)) u_dec (
    .size_code (cfg_size),
    .byte_addr (req_addr),
    .present   (present),
    .in_range  (in_range)
  );

  tcm_lane_gen u_lane (
    .is_write  (req_write),
    .acc_size  (req_size),
    .lsb       (req_addr[1:0]),
    .wdata     (req_wdata),
    .strb      (strb_d),
    .lane_data (lane_d)
  );

  req_state_t       st_q, st_d;
  logic [WAW-1:0]   addr_q;
  logic [NLANE-1:0] strb_q;
  logic [DW-1:0]    wdata_q;
  logic             wr_q;
  logic             accept, reject, finish, load_en;

  always_comb begin
    accept  = (st_q == ST_IDLE) && req_valid && in_range;
    reject  = (st_q == ST_IDLE) && req_valid && !in_range;
    finish  = (st_q == ST_REQ) && !tcm_wait;
    load_en = accept;
    st_d    = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_REQ;
      ST_REQ:  if (finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      strb_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_en) begin
        addr_q  <= req_addr[WAW+1:2];
        strb_q  <= strb_d;
        wdata_q <= lane_d;
        wr_q    <= req_write;
      end
    end
  end

  assign tcm_cs    = accept;
  assign tcm_addr  = addr_q;
  assign tcm_strb  = (st_q == ST_REQ) ? strb_q : '0;
  assign tcm_wdata = wdata_q;
  assign rsp_done  = finish;
  assign rsp_err   = reject;
  assign rsp_rdata = (finish && !wr_q) ? tcm_rdata : '0;

  assert_absent_no_cs_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !present |-> !tcm_cs);
  assert_err_no_cs_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_err |-> (!tcm_cs && !rsp_done));
  assert_cs_then_req_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    tcm_cs |=> (st_q == ST_REQ));
  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_REQ && tcm_wait) |=>
      (st_q == ST_REQ && !tcm_cs && $stable(tcm_addr) && $stable(tcm_strb) && $stable(tcm_wdata)));
  assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_done |=> (tcm_strb == '0));
  assert_strb_shape_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (tcm_strb != '0) |-> ($countones(tcm_strb) == 1 || $countones(tcm_strb) == 2 ||
                          $countones(tcm_strb) == 4));
endmodule

// File: tb/sim_tcm_req.sv
module sim_tcm_req;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_size;
  logic        req_valid, req_write, tcm_wait;
  logic [31:0] req_addr, req_wdata, tcm_rdata, rsp_rdata, tcm_wdata;
  logic [1:0]  req_size;
  logic        rsp_done, rsp_err, tcm_cs;
  logic [17:0] tcm_addr;
  logic [3:0]  tcm_strb;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tcm_req u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .tcm_cs(tcm_cs), .tcm_addr(tcm_addr),
    .tcm_strb(tcm_strb), .tcm_wdata(tcm_wdata), .tcm_wait(tcm_wait),
    .tcm_rdata(tcm_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ok(input logic [3:0] code, input logic [31:0] a);
    if (code < 4'd3 || code > 4'd11) return 1'b0;
    return (a >> (code + 9)) == 0;
  endfunction

  function automatic logic [3:0] exp_strb(input logic wr, input logic [1:0] sz, input logic [1:0] lsb);
    if (!wr) return 4'b0000;
    if (sz == 2'b00) return 4'b0001 << lsb;
    if (sz == 2'b01) return lsb[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {4{d[7:0]}};
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] d, input int waits, input logic idle_wait);
    logic [3:0]  es;
    logic [31:0] ed, rd;
    es = exp_strb(wr, sz, a[1:0]);
    ed = exp_data(sz, d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_wdata = d;
    tcm_wait = idle_wait;
    #1;
    if (!exp_ok(cfg_size, a)) begin
      chk("R2 err on reject", rsp_err, 1);
      chk("R1 cs low on reject", tcm_cs, 0);
      req_valid = 0; tcm_wait = 0;
      @(negedge clk); #1;
      chk("R2 idle after reject", {rsp_done, rsp_err, tcm_cs, tcm_strb}, 0);
      return;
    end
    chk("R3 cs on accept", tcm_cs, 1);
    chk("R6 no err/done idle", {rsp_err, rsp_done}, 0);
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      tcm_wait = (i < waits);
      rd = $urandom; tcm_rdata = rd;
      #1;
      chk("R3 word address", tcm_addr, a[19:2]);
      chk("R8 strobes", tcm_strb, es);
      chk("R9 write data", tcm_wdata, ed);
      chk("R4 cs low in request cycle", tcm_cs, 0);
      if (i < waits) begin
        chk("R5 no done while waited", rsp_done, 0);
        chk("R5 rdata zero while waited", rsp_rdata, 0);
      end else begin
        chk("R5 done", rsp_done, 1);
        chk("R5 rdata", rsp_rdata, wr ? 32'h0 : rd);
      end
    end
    req_valid = 0; tcm_wait = 0;
    @(negedge clk); #1;
    chk("R7 strobes off idle", tcm_strb, 0);
    chk("R5 done one cycle", {rsp_done, rsp_rdata}, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; cfg_size = 4'd11; req_valid = 0; req_addr = 0; req_write = 0;
    req_size = 0; req_wdata = 0; tcm_wait = 0; tcm_rdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk("R3 reset state", {rsp_done, rsp_err, tcm_cs, tcm_strb}, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R6: wait toggling while nothing is requested
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tcm_wait = i[0]; #1;
      chk("R6 wait ignored when idle", {rsp_done, rsp_err, tcm_cs, tcm_strb}, 0);
    end
    tcm_wait = 0;

    // R8/R9 directed lanes
    for (int l = 0; l < 4; l++) do_req(32'h100 + l, 2'b00, 1, 32'hA5C3_1E00 + l, 0, 0);
    do_req(32'h202, 2'b01, 1, 32'h1234_BEEF, 1, 1);
    do_req(32'h200, 2'b01, 1, 32'h1234_BEEF, 0, 0);
    do_req(32'h300, 2'b10, 1, 32'hDEAD_0001, 2, 0);
    do_req(32'h304, 2'b11, 1, 32'hDEAD_0002, 0, 1);
    do_req(32'h308, 2'b10, 0, 32'hFFFF_FFFF, 3, 0); // R7 read

    // R1/R2 sweep of every size code at capacity edges
    for (int c = 0; c < 16; c++) begin
      cfg_size = 4'(c);
      do_req(32'h0, 2'b10, 0, 0, 0, 0);
      if (c >= 3 && c <= 11) begin
        do_req((32'h1 << (c + 9)) - 4, 2'b10, 1, 32'h55AA_00FF, 1, 0);
        do_req(32'h1 << (c + 9), 2'b00, 1, 32'h11, 0, 0);
      end
    end

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if (n % 50 == 0) cfg_size = ($urandom % 4 == 0) ? 4'($urandom) : 4'(3 + $urandom % 9);
      a = $urandom;
      if ($urandom % 8 != 0) a = a & ((32'h1 << (4'(cfg_size) + 9)) - 1);
      do_req(a, 2'($urandom), 1'($urandom), $urandom, $urandom % 4, 1'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule